// File: doc/BRIEF.md
# I2C Controller Interrupt Status Collector

This block gathers the interrupt sources of an I2C controller into one raw status register, forms a masked view by AND-ing the raw bits with a software mask, and drives a single registered interrupt line. Ten of the sources are edge-type. Each one is set by a one-cycle event pulse and stays set until software clears it. Two sources, receive-full and transmit-empty, are level-type and simply follow threshold comparison inputs from the FIFO logic. The events themselves come from elsewhere in the controller.

Software clears edge-type sources by reading. Each source has its own clear address, and one further address clears every source at once. A transmit abort also records why it happened in a separate abort-reason register. Reading the abort clear address, or the clear-all address, empties that register together with the abort status bit. Read data is combinational from the address. The clearing side effect takes effect at the clock edge that ends the read cycle.

Top module: `i2c_irq_status`

## Requirements
- R1: Raw status (read at address 0x01) holds the sources in this bit order: 0 rx_under, 1 rx_over, 2 rx_full, 3 tx_over, 4 tx_empty, 5 rd_req, 6 tx_abrt, 7 rx_done, 8 activity, 9 stop_det, 10 start_det, 11 gen_call. A pulse on `evt[k]` for an edge-type bit k sets raw bit k at the next clock edge. Read bits 15..12 are zero.
- R2: Reading address 0x00 returns the raw status ANDed with the mask.
- R3: The mask register at address 0x02 is written from `wdata[11:0]` and read back at the same address. It resets to zero. Writes to any other address have no effect.
- R4: Reading address 0x10+k, for an edge-type bit k, returns the current value of raw bit k in read bit 0. The same read clears raw bit k and leaves every other bit unchanged.
- R5: Reading address 0x04 returns zero. It clears every edge-type raw bit and the abort-reason register.
- R6: Raw bits 2 and 4 follow `rx_full_lvl` and `tx_empty_lvl` with one cycle of delay. No clear read changes them. The event inputs `evt[2]` and `evt[4]` are ignored.
- R7: When an event pulse for bit k arrives in the same cycle as a read that clears bit k, the bit stays set.
- R8: Each tx_abrt pulse (`evt[6]`) ORs `abrt_src` into the abort-reason register (read at 0x03). Only reason positions 0-5, 7 and 9-12 are kept; the other positions always read zero.
- R9: Reading address 0x16 clears raw bit 6 and the whole abort-reason register. If an abort pulse arrives in that same cycle, the register then holds only the new reasons.
- R10: `irq` equals the OR of the masked status bits of the previous cycle. It is low after reset.
- R11: Reads of any address not listed above return zero and change no state. This includes 0x12 and 0x14, which belong to the level-type bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| evt | input | 12 | Event pulses for the edge-type sources, indexed by raw bit |
| rx_full_lvl | input | 1 | Receive threshold reached (level) |
| tx_empty_lvl | input | 1 | Transmit at or below threshold (level) |
| abrt_src | input | 16 | Abort reasons that accompany a tx_abrt pulse |
| irq | output | 1 | Registered interrupt output |

## Verification
The assertions check several properties on every cycle. An event always sets its bit on the following cycle, and a lone clear read always empties its bit. An abort clear empties both the abort status bit and the reason register. A clear-all read never disturbs the receive-full level. A zero mask keeps `irq` low, and unused reason positions never hold a one. The bench scenarios are needed for the rest. Only they show that a single-source clear leaves its neighbours untouched, that the read data at each address is correct, and that abort reasons from several pulses accumulate. They also show that reads of unmapped addresses change nothing, and that `irq` tracks the masked status across mixed random traffic.

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int CLR_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [11:0]       evt,
  input  logic              rx_full_lvl,
  input  logic              tx_empty_lvl,
  input  logic [15:0]       abrt_src,
  output logic              irq
);
  localparam int NSRC = 12;
  localparam logic [NSRC-1:0] EDGE_SRC = 12'hFEB;
  localparam logic [15:0] ABRT_KEEP = 16'h1EBF;
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ABRT   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CLRALL = ADDR_W'(4);
  localparam int TX_ABRT = 6;

  logic [NSRC-1:0] raw_q, mask_q, clr_hit;
  logic [15:0]     abrt_q, abrt_new;
  logic            clr_all, clr_abrt;

  wire unused_wdata = ^wdata[DATA_W-1:NSRC];

  assign clr_all  = rd_en && addr == A_CLRALL;
  assign clr_abrt = clr_all || clr_hit[TX_ABRT];
  assign abrt_new = evt[TX_ABRT] ? (abrt_src & ABRT_KEEP) : 16'h0;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    if (EDGE_SRC[k]) begin : g_edge
      assign clr_hit[k] = rd_en && addr == ADDR_W'(CLR_BASE + k);
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) raw_q[k] <= 1'b0;
        else        raw_q[k] <= evt[k] | (raw_q[k] & ~(clr_hit[k] | clr_all));
    end else begin : g_level
      wire unused_evt = evt[k];
      assign clr_hit[k] = 1'b0;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) raw_q[k] <= 1'b0;
        else        raw_q[k] <= (k == 2) ? rx_full_lvl : tx_empty_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     mask_q <= '0;
    else if (wr_en && addr == A_MASK) mask_q <= wdata[NSRC-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        abrt_q <= '0;
    else if (clr_abrt) abrt_q <= abrt_new;
    else               abrt_q <= abrt_q | abrt_new;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(raw_q & mask_q);

  always_comb begin
    rdata = '0;
    if (addr == A_MASKED)    rdata[NSRC-1:0] = raw_q & mask_q;
    else if (addr == A_RAW)  rdata[NSRC-1:0] = raw_q;
    else if (addr == A_MASK) rdata[NSRC-1:0] = mask_q;
    else if (addr == A_ABRT) rdata[15:0] = abrt_q;
    else
      for (int k = 0; k < NSRC; k++)
        if (EDGE_SRC[k] && addr == ADDR_W'(CLR_BASE + k)) rdata[0] = raw_q[k];
  end
endmodule

module i2c_irq_status_chk #(
  parameter int ADDR_W   = 5,
  parameter int CLR_BASE = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [11:0]       evt,
  input logic              rx_full_lvl,
  input logic [11:0]       raw_q,
  input logic [11:0]       mask_q,
  input logic [15:0]       abrt_q,
  input logic              irq
);
  localparam logic [11:0] EDGE_SRC = 12'hFEB;

  for (genvar k = 0; k < 12; k++) begin : g_chk
    if (EDGE_SRC[k]) begin : g_edge
      assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt[k] |=> raw_q[k]);
      assert_clear_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(CLR_BASE + k) && !evt[k]) |=> !raw_q[k]);
    end
  end

  assert_level_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(4) && rx_full_lvl) |=> raw_q[2]);

  assert_abort_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(CLR_BASE + 6) && !evt[6]) |=> (abrt_q == 16'h0 && !raw_q[6]));

  assert_reason_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abrt_q & ~16'h1EBF) == 16'h0);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 12'h0) |=> !irq);
endmodule

bind i2c_irq_status i2c_irq_status_chk #(.ADDR_W(ADDR_W), .CLR_BASE(CLR_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .evt(evt),
  .rx_full_lvl(rx_full_lvl), .raw_q(raw_q), .mask_q(mask_q), .abrt_q(abrt_q), .irq(irq)
);

// File: tb/i2c_irq_status_bench.sv
module i2c_irq_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0, abrt_src = '0;
  logic [15:0] rdata;
  logic [11:0] evt = '0;
  logic rx_full_lvl = 1'b0, tx_empty_lvl = 1'b0;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [11:0] raw_m = '0, mask_m = '0;
  logic [15:0] abrt_m = '0;
  logic irq_m = 1'b0;
  localparam logic [11:0] EDGE = 12'hFEB;
  localparam logic [15:0] KEEP = 16'h1EBF;

  always #5 clk = ~clk;

  i2c_irq_status u_i2c_irq_status (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt(evt), .rx_full_lvl(rx_full_lvl),
    .tx_empty_lvl(tx_empty_lvl), .abrt_src(abrt_src), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [4:0] a);
    logic [15:0] r = '0;
    if (a == 5'd0) r[11:0] = raw_m & mask_m;
    else if (a == 5'd1) r[11:0] = raw_m;
    else if (a == 5'd2) r[11:0] = mask_m;
    else if (a == 5'd3) r = abrt_m;
    else if (a >= 5'd16 && a < 5'd28 && EDGE[a-5'd16]) r[0] = raw_m[a-5'd16];
    return r;
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    if (a == 5'd0) return "R2";
    if (a == 5'd1) return "R1";
    if (a == 5'd2) return "R3";
    if (a == 5'd3) return "R8";
    if (a == 5'd4) return "R5";
    if (a >= 5'd16 && a < 5'd28 && EDGE[a-5'd16]) return "R4";
    return "R11";
  endfunction

  task automatic cyc(input logic [11:0] e, input logic [15:0] src, input logic rxl, input logic txl,
                     input logic rd, input logic wr, input logic [4:0] a, input logic [15:0] wd);
    logic [11:0] clr;
    logic cab;
    logic [15:0] nw;
    evt = e; abrt_src = src; rx_full_lvl = rxl; tx_empty_lvl = txl;
    rd_en = rd; wr_en = wr; addr = a; wdata = wd;
    #1;
    if (rd) check(tag_of(a), rdata, exp_rd(a));
    check("R10", {15'b0, irq}, {15'b0, irq_m});
    @(posedge clk);
    clr = '0;
    if (rd && a == 5'd4) clr = EDGE;
    if (rd && a >= 5'd16 && a < 5'd28) clr[a-5'd16] = EDGE[a-5'd16];
    cab = rd && (a == 5'd4 || a == 5'd22);
    nw = e[6] ? (src & KEEP) : 16'h0;
    irq_m = |(raw_m & mask_m);
    raw_m = (raw_m & ~clr) | (e & EDGE);
    raw_m[2] = rxl;
    raw_m[4] = txl;
    abrt_m = cab ? nw : (abrt_m | nw);
    if (wr && a == 5'd2) mask_m = wd[11:0];
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, input logic [11:0] e = '0, input logic rxl = 1'b0);
    cyc(e, 16'h0, rxl, 1'b0, 1'b1, 1'b0, a, 16'h0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state: R3 mask zero, R1 raw zero, R10 irq low
    rd(5'd2); rd(5'd1); rd(5'd3);
    // R3 write mask, write to RAW ignored
    cyc('0, 0, 0, 0, 0, 1, 5'd2, 16'hFFFF);
    cyc('0, 0, 0, 0, 0, 1, 5'd1, 16'hFFFF);
    rd(5'd2); rd(5'd1);
    // R1 event on stop_det bit 9, R10 irq follows
    cyc(12'h200, 0, 0, 0, 0, 0, 5'd0, 0);
    rd(5'd0); rd(5'd1);
    // R7 event wins over clear in same cycle
    rd(5'd25, 12'h200);
    rd(5'd1);
    // R4 single clear leaves others
    cyc(12'h801, 0, 0, 0, 0, 0, 5'd0, 0);
    rd(5'd25); rd(5'd1); rd(5'd16); rd(5'd1);
    // R8 abort capture, only kept positions; accumulate
    cyc(12'h040, 16'h0001, 0, 0, 0, 0, 5'd0, 0);
    cyc(12'h040, 16'hFFFE, 0, 0, 0, 0, 5'd0, 0);
    rd(5'd3); rd(5'd1);
    // R9 abort clear
    rd(5'd22); rd(5'd3); rd(5'd1);
    // R9 clear with a new abort the same cycle
    cyc(12'h040, 16'h0008, 0, 0, 0, 0, 5'd0, 0);
    cyc(12'h040, 16'h1000, 0, 0, 1, 0, 5'd22, 0);
    rd(5'd3);
    // R6 levels survive clear-all, R11 level clear addresses do nothing
    cyc(12'hFFF, 16'hFFFF, 1, 1, 0, 0, 5'd0, 0);
    rd(5'd18, '0, 1'b1); rd(5'd20, '0, 1'b1); rd(5'd1, '0, 1'b1);
    rd(5'd4, '0, 1'b1); rd(5'd1, '0, 1'b1); rd(5'd3, '0, 1'b1);
    rd(5'd31); rd(5'd1);
    // R10 mask zero silences irq
    cyc('0, 0, 1, 1, 0, 1, 5'd2, 16'h0);
    rd(5'd0, '0, 1'b1); rd(5'd0, '0, 1'b1);
    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] e;
      logic [4:0] a;
      logic r, w;
      int pick;
      e = '0;
      for (int b = 0; b < 12; b++) e[b] = ($urandom % 8) == 0;
      pick = $urandom % 9;
      case (pick)
        0: a = 5'd0; 1: a = 5'd1; 2: a = 5'd2; 3: a = 5'd3; 4: a = 5'd4;
        5: a = 5'd31; 6: a = 5'd9;
        default: a = 5'(16 + $urandom % 12);
      endcase
      r = ($urandom % 3) != 0;
      w = !r && ($urandom % 4) == 0;
      if (w) a = ($urandom % 2) ? 5'd2 : 5'($urandom % 32);
      cyc(e, 16'($urandom), 1'($urandom), 1'($urandom), r, w, a, 16'($urandom));
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule